// File: doc/BRIEF.md
# Eight-Bank External Memory Access Controller

This block sits between a CPU's simple request port and an external asynchronous memory bus. It compares each request address against eight bank windows and selects one bank. Seven windows sit at fixed 32 MB slots, and their used length is programmable. The eighth window can be placed anywhere in the 256 MB space, and both its start and its length are programmable in 1 MB units. The block then asserts that bank's active-low chip select and runs the access with the bank's own data width, strobe length and wait policy.

A 32-bit CPU word that goes to a narrower bank is carried as a series of beats, starting at the lowest address. On reads the beats are assembled back into one word. Ready goes back to the CPU for one cycle once the whole word is done. A request that no window claims gets an immediate empty response.

Top module: `xbank_mem_ctrl`

## Requirements
- R1: For k in 0..6, an address whose bits [27:25] equal k and whose bits [24:20] are below bank k's size field asserts cs_n_o[k] alone for the whole access. At most one chip select is ever low.
- R2: Bank 7 claims addresses whose bits [27:20] lie in [flex_base_i, flex_base_i + size7). Where it overlaps a fixed bank's claimed range, the fixed bank wins.
- R3: An address claimed by no bank asserts no chip select and no strobe. rdy_o goes high in the first cycle after the request is sampled, with rdata_o equal to zero.
- R4: Width code 0 selects 8 bits (four beats), code 1 selects 16 bits (two beats), and codes 2 and 3 select 32 bits (one beat). Beat addresses start at the word-aligned request address and step up by the beat size.
- R5: Read beats are placed little-endian, with the lowest address in the lowest bits. rdy_o rises in the cycle after the last strobe clock of the last beat.
- R6: A write drives the beat's bytes on the lowest lanes of ext_wdata_o. ext_be_n_o is active low and carries the request byte enables that belong to that beat. A write drives we_n_o and never oe_n_o, and a read does the reverse.
- R7: A cycle code c in 0..7 holds the strobe for c+1 clocks per beat. Consecutive beats follow one another with no gap.
- R8: When a bank's wait enable is set, a high wait_i on the last strobe clock of a beat extends that clock for as long as wait_i stays high. When the wait enable is clear, wait_i has no effect.
- R9: After reset, all chip selects and strobes are inactive and rdy_o is low. rdy_o is a one-cycle pulse.
- R10: A size field of 0 disables a bank. Any size above 32 acts as 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | CPU request, held until rdy_o |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 28 | CPU byte address (bits [1:0] ignored) |
| be_i | input | 4 | Byte enables of the word |
| wdata_i | input | 32 | Write word |
| rdy_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 32 | Read word, valid with rdy_o |
| bank_width_i | input | 16 | Two-bit width code per bank |
| bank_cyc_i | input | 24 | Three-bit cycle code per bank |
| bank_wait_en_i | input | 8 | Per-bank wait enable |
| bank_size_i | input | 48 | Six-bit size per bank in MB |
| flex_base_i | input | 8 | Start of bank 7 in MB |
| cs_n_o | output | 8 | Active-low chip selects |
| ext_addr_o | output | 28 | External byte address of the beat |
| ext_wdata_o | output | 32 | External write data |
| ext_be_n_o | output | 4 | Active-low lane enables |
| ext_rdata_i | input | 32 | External read data |
| oe_n_o | output | 1 | Active-low read strobe |
| we_n_o | output | 1 | Active-low write strobe |
| wait_i | input | 1 | External wait, active high |

## Verification
The hardest case to reach is a wait that arrives on exactly the last strobe clock of a beat, and not on one of the earlier countdown clocks. The bench's bus model counts strobe clocks as they happen and keeps wait_i high through a chosen number of them. By choosing that number relative to the bank's cycle code, a test can stall the last clock a known number of times or leave the earlier clocks unaffected. The overlap between the movable bank and a short fixed bank is reached by moving the movable window next to the fixed bank's limit and probing addresses on both sides of that limit.

// File: rtl/xbank_pkg.sv
package xbank_pkg;

  localparam int DW    = 32;
  localparam int NLANE = DW / 8;

  typedef enum logic [1:0] {
    BW_8   = 2'd0,
    BW_16  = 2'd1,
    BW_32  = 2'd2,
    BW_32X = 2'd3
  } bw_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_STRB = 2'd1,
    ST_RESP = 2'd2
  } st_e;

  // index of the final beat for a width code
  function automatic logic [1:0] last_beat(input bw_e w);
    case (w)
      BW_8:    last_beat = 2'd3;
      BW_16:   last_beat = 2'd1;
      default: last_beat = 2'd0;
    endcase
  endfunction

  // log2 of the beat size in bytes
  function automatic logic [1:0] beat_shift(input bw_e w);
    case (w)
      BW_8:    beat_shift = 2'd0;
      BW_16:   beat_shift = 2'd1;
      default: beat_shift = 2'd2;
    endcase
  endfunction

endpackage

// File: rtl/xbank_decode.sv
module xbank_decode
  import xbank_pkg::*;
#(
  parameter int NBANK  = 8,
  parameter int ADDR_W = 28,
  parameter int SLOT_W = 25,
  parameter int UNIT_W = 20,
  parameter int SIZE_W = 6,
  parameter int MB_W   = 8,
  parameter int IDX_W  = 3
) (
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [SIZE_W*NBANK-1:0] size_i,
  input  logic [MB_W-1:0]         flex_base_i,
  output logic                    hit_o,
  output logic [NBANK-1:0]        sel_o,
  output logic [IDX_W-1:0]        idx_o
);

  localparam int SEL_W      = ADDR_W - SLOT_W;
  localparam int OFS_W      = SLOT_W - UNIT_W;
  localparam int SLOT_UNITS = 1 << OFS_W;

  logic [NBANK-1:0]  raw;
  logic [MB_W-1:0]   unit_no;
  logic [MB_W-1:0]   flex_dist;
  logic [SIZE_W-1:0] eff [NBANK];

  assign unit_no   = addr_i[ADDR_W-1:UNIT_W];
  assign flex_dist = unit_no - flex_base_i;

  generate
    for (genvar k = 0; k < NBANK; k++) begin : g_bank
      logic [SIZE_W-1:0] sz;
      assign sz     = size_i[SIZE_W*k +: SIZE_W];
      assign eff[k] = (32'(sz) > SLOT_UNITS) ? SIZE_W'(SLOT_UNITS) : sz;
      if (k < NBANK - 1) begin : g_fixed
        assign raw[k] = (addr_i[ADDR_W-1:SLOT_W] == SEL_W'(k)) &&
                        (32'(addr_i[SLOT_W-1:UNIT_W]) < 32'(eff[k]));
      end else begin : g_flex
        assign raw[k] = (unit_no >= flex_base_i) &&
                        (32'(flex_dist) < 32'(eff[k]));
      end
    end
  endgenerate

  // lowest index wins, so fixed banks shadow the movable one
  always_comb begin
    hit_o = 1'b0;
    sel_o = '0;
    idx_o = '0;
    for (int k = NBANK - 1; k >= 0; k--) begin
      if (raw[k]) begin
        hit_o    = 1'b1;
        sel_o    = '0;
        sel_o[k] = 1'b1;
        idx_o    = IDX_W'(k);
      end
    end
  end

endmodule

// File: rtl/xbank_lane.sv
module xbank_lane
  import xbank_pkg::*;
(
  input  bw_e             wid_i,
  input  logic [1:0]      beat_i,
  input  logic [DW-1:0]   wdata_i,
  input  logic [NLANE-1:0] be_i,
  input  logic [DW-1:0]   ext_rdata_i,
  input  logic [DW-1:0]   acc_i,
  output logic [DW-1:0]   wdata_o,
  output logic [NLANE-1:0] be_n_o,
  output logic [DW-1:0]   acc_o
);

  always_comb begin
    wdata_o = wdata_i;
    be_n_o  = ~be_i;
    acc_o   = acc_i;
    case (wid_i)
      BW_8: begin
        wdata_o                  = '0;
        wdata_o[7:0]             = wdata_i[8*beat_i +: 8];
        be_n_o                   = '1;
        be_n_o[0]                = ~be_i[beat_i];
        acc_o[8*beat_i +: 8]     = ext_rdata_i[7:0];
      end
      BW_16: begin
        wdata_o                  = '0;
        wdata_o[15:0]            = wdata_i[16*beat_i[0] +: 16];
        be_n_o                   = '1;
        be_n_o[1:0]              = ~be_i[2*beat_i[0] +: 2];
        acc_o[16*beat_i[0] +: 16] = ext_rdata_i[15:0];
      end
      default: begin
        acc_o = ext_rdata_i;
      end
    endcase
  end

endmodule

// File: rtl/xbank_seq.sv
module xbank_seq
  import xbank_pkg::*;
#(
  parameter int NBANK  = 8,
  parameter int ADDR_W = 28,
  parameter int CYC_W  = 3,
  parameter int IDX_W  = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_i,
  input  logic                   we_i,
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic [NLANE-1:0]       be_i,
  input  logic [DW-1:0]          wdata_i,
  input  logic                   hit_i,
  input  logic [NBANK-1:0]       sel_i,
  input  logic [IDX_W-1:0]       idx_i,
  input  logic [2*NBANK-1:0]     width_i,
  input  logic [CYC_W*NBANK-1:0] cyc_i,
  input  logic [NBANK-1:0]       wait_en_i,
  input  logic                   wait_i,
  input  logic [DW-1:0]          ext_rdata_i,
  output logic [NBANK-1:0]       cs_n_o,
  output logic [ADDR_W-1:0]      ext_addr_o,
  output logic [DW-1:0]          ext_wdata_o,
  output logic [NLANE-1:0]       ext_be_n_o,
  output logic                   oe_n_o,
  output logic                   we_n_o,
  output logic                   rdy_o,
  output logic [DW-1:0]          rdata_o
);

  st_e               state_q, state_d;
  logic [NBANK-1:0]  sel_q;
  logic [ADDR_W-1:0] base_q;
  logic              we_q;
  logic [NLANE-1:0]  be_q;
  logic [DW-1:0]     wdata_q;
  bw_e               wid_q;
  logic [CYC_W-1:0]  cyc_q, cnt_q, cnt_d;
  logic              wten_q;
  logic [1:0]        beat_q, beat_d;
  logic [DW-1:0]     acc_q, acc_d, acc_mrg;
  logic              ld;
  logic              strb;

  bw_e               wid_sel;
  logic [CYC_W-1:0]  cyc_sel;

  assign wid_sel = bw_e'(width_i[2*idx_i +: 2]);
  assign cyc_sel = cyc_i[CYC_W*idx_i +: CYC_W];

  xbank_lane i_lane (
    .wid_i       (wid_q),
    .beat_i      (beat_q),
    .wdata_i     (wdata_q),
    .be_i        (be_q),
    .ext_rdata_i (ext_rdata_i),
    .acc_i       (acc_q),
    .wdata_o     (ext_wdata_o),
    .be_n_o      (ext_be_n_o),
    .acc_o       (acc_mrg)
  );

  // next state
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    beat_d  = beat_q;
    acc_d   = acc_q;
    ld      = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (req_i) begin
          ld      = 1'b1;
          acc_d   = '0;
          beat_d  = '0;
          cnt_d   = cyc_sel;
          state_d = hit_i ? ST_STRB : ST_RESP;
        end
      end
      ST_STRB: begin
        if (cnt_q != '0) begin
          cnt_d = cnt_q - 1'b1;
        end else if (wten_q && wait_i) begin
          cnt_d = cnt_q;
        end else begin
          acc_d = acc_mrg;
          if (beat_q == last_beat(wid_q)) begin
            state_d = ST_RESP;
          end else begin
            beat_d = beat_q + 1'b1;
            cnt_d  = cyc_q;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      beat_q  <= '0;
      acc_q   <= '0;
      sel_q   <= '0;
      base_q  <= '0;
      we_q    <= 1'b0;
      be_q    <= '0;
      wdata_q <= '0;
      wid_q   <= BW_32;
      cyc_q   <= '0;
      wten_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      beat_q  <= beat_d;
      acc_q   <= acc_d;
      if (ld) begin
        sel_q   <= hit_i ? sel_i : '0;
        base_q  <= {addr_i[ADDR_W-1:2], 2'b00};
        we_q    <= we_i;
        be_q    <= be_i;
        wdata_q <= wdata_i;
        wid_q   <= wid_sel;
        cyc_q   <= cyc_sel;
        wten_q  <= wait_en_i[idx_i];
      end
    end
  end

  assign strb       = (state_q == ST_STRB);
  assign cs_n_o     = ~(sel_q & {NBANK{strb}});
  assign oe_n_o     = ~(strb & ~we_q);
  assign we_n_o     = ~(strb & we_q);
  assign ext_addr_o = base_q + (ADDR_W'(beat_q) << beat_shift(wid_q));
  assign rdy_o      = (state_q == ST_RESP);
  assign rdata_o    = acc_q;

  // R9
  rdy_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_o |=> !rdy_o);

  // R7
  strb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strb && cnt_q != '0) |=> (strb && $stable(beat_q)));

  // R8
  wait_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strb && cnt_q == '0 && wten_q && wait_i) |=>
      (strb && $stable(beat_q) && cnt_q == '0));

  // R5
  last_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy_o && $past(strb)) |-> ($past(beat_q) == last_beat($past(wid_q))));

  // R3
  miss_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && req_i && !hit_i) |=>
      (rdy_o && (&cs_n_o) && oe_n_o && we_n_o && rdata_o == '0));

endmodule

// File: rtl/xbank_mem_ctrl.sv
module xbank_mem_ctrl
  import xbank_pkg::*;
#(
  parameter int NBANK  = 8,
  parameter int ADDR_W = 28,
  parameter int SLOT_W = 25,
  parameter int UNIT_W = 20,
  parameter int CYC_W  = 3,
  localparam int SIZE_W = (SLOT_W - UNIT_W) + 1,
  localparam int MB_W   = ADDR_W - UNIT_W,
  localparam int IDX_W  = $clog2(NBANK)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_i,
  input  logic                    we_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [NLANE-1:0]        be_i,
  input  logic [DW-1:0]           wdata_i,
  output logic                    rdy_o,
  output logic [DW-1:0]           rdata_o,
  input  logic [2*NBANK-1:0]      bank_width_i,
  input  logic [CYC_W*NBANK-1:0]  bank_cyc_i,
  input  logic [NBANK-1:0]        bank_wait_en_i,
  input  logic [SIZE_W*NBANK-1:0] bank_size_i,
  input  logic [MB_W-1:0]         flex_base_i,
  output logic [NBANK-1:0]        cs_n_o,
  output logic [ADDR_W-1:0]       ext_addr_o,
  output logic [DW-1:0]           ext_wdata_o,
  output logic [NLANE-1:0]        ext_be_n_o,
  input  logic [DW-1:0]           ext_rdata_i,
  output logic                    oe_n_o,
  output logic                    we_n_o,
  input  logic                    wait_i
);

  // reset asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  logic             hit;
  logic [NBANK-1:0] sel;
  logic [IDX_W-1:0] idx;

  xbank_decode #(
    .NBANK (NBANK), .ADDR_W (ADDR_W), .SLOT_W (SLOT_W), .UNIT_W (UNIT_W),
    .SIZE_W(SIZE_W), .MB_W (MB_W), .IDX_W (IDX_W)
  ) i_decode (
    .addr_i      (addr_i),
    .size_i      (bank_size_i),
    .flex_base_i (flex_base_i),
    .hit_o       (hit),
    .sel_o       (sel),
    .idx_o       (idx)
  );

  xbank_seq #(
    .NBANK (NBANK), .ADDR_W (ADDR_W), .CYC_W (CYC_W), .IDX_W (IDX_W)
  ) i_seq (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .req_i       (req_i),
    .we_i        (we_i),
    .addr_i      (addr_i),
    .be_i        (be_i),
    .wdata_i     (wdata_i),
    .hit_i       (hit),
    .sel_i       (sel),
    .idx_i       (idx),
    .width_i     (bank_width_i),
    .cyc_i       (bank_cyc_i),
    .wait_en_i   (bank_wait_en_i),
    .wait_i      (wait_i),
    .ext_rdata_i (ext_rdata_i),
    .cs_n_o      (cs_n_o),
    .ext_addr_o  (ext_addr_o),
    .ext_wdata_o (ext_wdata_o),
    .ext_be_n_o  (ext_be_n_o),
    .oe_n_o      (oe_n_o),
    .we_n_o      (we_n_o),
    .rdy_o       (rdy_o),
    .rdata_o     (rdata_o)
  );

  // R1
  cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    $onehot0(~cs_n_o));

  // R6
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    !(!oe_n_o && !we_n_o));

  // R3
  strobe_needs_cs_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!oe_n_o || !we_n_o) |-> $countones(~cs_n_o) == 1);

endmodule

// File: tb/test_xbank_mem_ctrl.sv
module test_xbank_mem_ctrl;

  localparam time TCLK = 10ns;
  localparam int  MB   = 1 << 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [27:0] addr = '0;
  logic [3:0]  be = '0;
  logic [31:0] wdata = '0;
  logic        rdy;
  logic [31:0] rdata;
  logic [15:0] bwidth = '0;
  logic [23:0] bcyc = '0;
  logic [7:0]  bwten = '0;
  logic [47:0] bsize = '0;
  logic [7:0]  fbase = '0;
  logic [7:0]  cs_n;
  logic [27:0] eaddr;
  logic [31:0] ewdata, erdata;
  logic [3:0]  ebe_n;
  logic        oe_n, we_n;
  logic        wait_s;

  int n_chk = 0, n_fail = 0;

  always #(TCLK/2) clk = ~clk;

  xbank_mem_ctrl i_xbank_mem_ctrl (
    .clk(clk), .rst_n(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .be_i(be), .wdata_i(wdata), .rdy_o(rdy), .rdata_o(rdata),
    .bank_width_i(bwidth), .bank_cyc_i(bcyc), .bank_wait_en_i(bwten),
    .bank_size_i(bsize), .flex_base_i(fbase), .cs_n_o(cs_n),
    .ext_addr_o(eaddr), .ext_wdata_o(ewdata), .ext_be_n_o(ebe_n),
    .ext_rdata_i(erdata), .oe_n_o(oe_n), .we_n_o(we_n), .wait_i(wait_s)
  );

  function automatic logic [7:0] pat(input logic [27:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ {4'h0, a[27:24]} ^ 8'hA5;
  endfunction

  function automatic logic [31:0] word_at(input logic [27:0] a);
    return {pat(a + 28'd3), pat(a + 28'd2), pat(a + 28'd1), pat(a)};
  endfunction

  assign erdata = word_at(eaddr);

  // bus monitor, sole driver of its state and of wait_s
  logic        mon_on = 1'b0;
  int          wait_hold = 0;
  int          strb_cnt;
  int          nbeat;
  logic [7:0]  cs_seen;
  logic        saw_oe, saw_we;
  logic [27:0] baddr [8];
  logic [7:0]  mem [64];
  logic [63:0] wmask;

  initial wait_s = 1'b0;

  always @(negedge clk) begin
    if (!mon_on) begin
      strb_cnt = 0; nbeat = 0; cs_seen = '0; saw_oe = 0; saw_we = 0;
      wmask = '0;
      for (int i = 0; i < 8; i++) baddr[i] = '0;
      for (int i = 0; i < 64; i++) mem[i] = '0;
      wait_s = 1'b0;
    end else begin
      cs_seen = cs_seen | ~cs_n;
      if (!oe_n || !we_n) begin
        strb_cnt++;
        if (!oe_n) saw_oe = 1;
        if (!we_n) saw_we = 1;
        if (nbeat == 0 || eaddr != baddr[(nbeat - 1) % 8]) begin
          baddr[nbeat % 8] = eaddr;
          nbeat++;
        end
        if (!we_n)
          for (int j = 0; j < 4; j++)
            if (!ebe_n[j]) begin
              mem[(int'(eaddr[5:0]) + j) % 64] = ewdata[8*j +: 8];
              wmask[(int'(eaddr[5:0]) + j) % 64] = 1'b1;
            end
      end
      wait_s = (strb_cnt <= wait_hold) && (wait_hold > 0);
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cfg(input int k, input logic [1:0] w, input logic [2:0] c,
                     input logic wt, input logic [5:0] sz);
    bwidth[2*k +: 2] = w;
    bcyc[3*k +: 3]   = c;
    bwten[k]         = wt;
    bsize[6*k +: 6]  = sz;
  endtask

  int          lat;
  logic [31:0] rd_got;

  task automatic access(input logic w, input logic [27:0] a, input logic [3:0] b,
                        input logic [31:0] d, input int hold);
    @(negedge clk); mon_on = 0;
    @(negedge clk); #1;
    wait_hold = hold; mon_on = 1;
    req = 1; we = w; addr = a; be = b; wdata = d;
    lat = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk); #1; lat++;
      if (rdy) break;
    end
    rd_got = rdata;
    req = 0;
    @(negedge clk); #1;
    chk(!rdy, "R9 rdy pulse", 32'(rdy), 0);
  endtask

  task automatic t_reset;
    chk(cs_n == 8'hFF, "R9 reset cs", 32'(cs_n), 32'hFF);
    chk(oe_n && we_n, "R9 reset strobes", {30'd0, oe_n, we_n}, 3);
    chk(!rdy, "R9 reset rdy", 32'(rdy), 0);
  endtask

  task automatic t_read32;
    logic [27:0] a = 28'h0000_120;
    access(0, a, 4'hF, 0, 0);
    chk(rd_got == word_at(a), "R5 read32 data", rd_got, word_at(a));
    chk(cs_seen == 8'h01, "R1 read32 cs", 32'(cs_seen), 1);
    chk(strb_cnt == 1, "R7 code0 strobe", strb_cnt, 1);
    chk(nbeat == 1, "R4 one beat", nbeat, 1);
    chk(lat == 2, "R5 latency", lat, 2);
    chk(saw_oe && !saw_we, "R6 read strobe", {saw_oe, saw_we}, 2);
  endtask

  task automatic t_read16;
    logic [27:0] a = 28'(1*32*MB + 'h204);
    access(0, a + 28'd2, 4'hF, 0, 0);
    chk(rd_got == word_at(a), "R5 read16 data", rd_got, word_at(a));
    chk(nbeat == 2, "R4 two beats", nbeat, 2);
    chk(baddr[0] == a && baddr[1] == a + 28'd2, "R4 beat16 order",
        32'(baddr[1]), 32'(a + 28'd2));
    chk(strb_cnt == 4, "R7 code1 strobe", strb_cnt, 4);
    chk(lat == 5, "R5 rdy after last beat", lat, 5);
    chk(cs_seen == 8'h02, "R1 bank1 cs", 32'(cs_seen), 2);
  endtask

  task automatic t_read8;
    logic [27:0] a = 28'(2*32*MB + 'h10);
    access(0, a, 4'hF, 0, 0);
    chk(rd_got == word_at(a), "R5 read8 data", rd_got, word_at(a));
    chk(nbeat == 4, "R4 four beats", nbeat, 4);
    chk(baddr[0] == a && baddr[3] == a + 28'd3, "R4 beat8 order",
        32'(baddr[3]), 32'(a + 28'd3));
    chk(strb_cnt == 4, "R7 back to back beats", strb_cnt, 4);
  endtask

  task automatic t_write8;
    logic [27:0] a = 28'(2*32*MB + 'h20);
    access(1, a, 4'b1011, 32'h1122_3344, 0);
    chk(mem[32] == 8'h44 && mem[33] == 8'h33 && mem[35] == 8'h11,
        "R6 write8 bytes", {mem[35], mem[34], mem[33], mem[32]}, 32'h1100_3344);
    chk(wmask[35:32] == 4'b1011, "R6 masked byte untouched", 32'(wmask[35:32]), 32'hB);
    chk(saw_we && !saw_oe, "R6 write strobe", {saw_oe, saw_we}, 1);
  endtask

  task automatic t_write16;
    logic [27:0] a = 28'(1*32*MB + 'h10);
    access(1, a, 4'hF, 32'hCAFE_F00D, 0);
    chk({mem[19], mem[18], mem[17], mem[16]} == 32'hCAFE_F00D, "R6 write16 lanes",
        {mem[19], mem[18], mem[17], mem[16]}, 32'hCAFE_F00D);
    chk(nbeat == 2, "R4 write16 beats", nbeat, 2);
  endtask

  task automatic t_miss;
    access(0, 28'(4*32*MB + 'h40), 4'hF, 0, 0);
    chk(lat == 1, "R3 miss latency", lat, 1);
    chk(rd_got == 0, "R3 miss data", rd_got, 0);
    chk(cs_seen == 0 && strb_cnt == 0, "R10 size0 no cs", 32'(cs_seen), 0);
  endtask

  task automatic t_size;
    access(0, 28'(3*32*MB + 3*MB + 'h40), 4'hF, 0, 0);
    chk(cs_seen == 8'h08 && strb_cnt == 3, "R1 inside short bank",
        strb_cnt, 3);
    access(0, 28'(3*32*MB + 5*MB), 4'hF, 0, 0);
    chk(cs_seen == 0 && lat == 1, "R1 beyond short bank", 32'(cs_seen), 0);
    access(0, 28'(5*32*MB + 31*MB + 'h8), 4'hF, 0, 0);
    chk(cs_seen == 8'h20, "R10 oversize clips to full", 32'(cs_seen), 32'h20);
  endtask

  task automatic t_wait;
    access(0, 28'h0000_040, 4'hF, 0, 2);
    chk(strb_cnt == 3, "R8 code0 wait", strb_cnt, 3);
    access(0, 28'(3*32*MB + 'h80), 4'hF, 0, 4);
    chk(strb_cnt == 5, "R8 wait on last clock only", strb_cnt, 5);
    access(0, 28'(6*32*MB + 'h100), 4'hF, 0, 5);
    chk(strb_cnt == 1, "R8 wait ignored", strb_cnt, 1);
    chk(nbeat == 1, "R4 width code3", nbeat, 1);
  endtask

  task automatic t_flex;
    logic [27:0] a = 28'(230*MB + 'h100);
    fbase = 8'd228;
    access(0, a, 4'hF, 0, 0);
    chk(cs_seen == 8'h80 && rd_got == word_at(a), "R2 flex hit", 32'(cs_seen), 32'h80);
    chk(nbeat == 2, "R2 flex width", nbeat, 2);
    access(0, 28'(236*MB), 4'hF, 0, 0);
    chk(cs_seen == 0 && lat == 1, "R2 flex end", 32'(cs_seen), 0);
    fbase = 8'd98;
    access(0, 28'(99*MB), 4'hF, 0, 0);
    chk(cs_seen == 8'h08, "R2 fixed wins", 32'(cs_seen), 8);
    access(0, 28'(101*MB), 4'hF, 0, 0);
    chk(cs_seen == 8'h80, "R2 flex beyond fixed", 32'(cs_seen), 32'h80);
    access(0, 28'(97*MB), 4'hF, 0, 0);
    chk(cs_seen == 8'h08, "R2 below flex base", 32'(cs_seen), 8);
  endtask

  initial begin
    cfg(0, 2'd2, 3'd0, 1'b1, 6'd32);
    cfg(1, 2'd1, 3'd1, 1'b0, 6'd32);
    cfg(2, 2'd0, 3'd0, 1'b0, 6'd32);
    cfg(3, 2'd2, 3'd2, 1'b1, 6'd4);
    cfg(4, 2'd2, 3'd0, 1'b0, 6'd0);
    cfg(5, 2'd2, 3'd0, 1'b0, 6'd63);
    cfg(6, 2'd3, 3'd0, 1'b0, 6'd32);
    cfg(7, 2'd1, 3'd0, 1'b0, 6'd8);
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    #1 t_reset();
    t_read32();
    t_read16();
    t_read8();
    t_write8();
    t_write16();
    t_miss();
    t_size();
    t_wait();
    t_flex();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk + 1, n_fail + 1);
    $finish;
  end

endmodule